// File: doc/BRIEF.md
# XOR-Encoded Multi-Port RAM

This block is a memory with several independent write ports and several independent read ports. It keeps one storage bank per write port. It has no table that records which port wrote an address last. A word is spread over the banks with XOR encoding instead. When port k writes an address, bank k stores the new data XORed with the contents that every other bank holds at that address. A later XOR of all banks at that address then cancels the other contributions and gives back the new data.

Each write port reads the other banks at its own write address in the same cycle as the write, through feedback reads. Each read port XORs all banks at its read address and registers the result, so read data appears one cycle after the address. With bypass enabled, a read that hits an address being written in the same cycle returns the data being written. A read in the cycle after a write sees the new data without any bypass.

Top module: `xor_mpram`

## Requirements
- R1: After reset every bank holds zero, so `rd_data` is zero during reset and every address reads back zero until it is written.
- R2: Read data for the address a read port presents in cycle t appears on that port's `rd_data` slice in cycle t+1, and it holds while the address and memory contents do not change.
- R3: A read returns the data most recently written to that address, whichever write port wrote it, including when a different port overwrote an earlier write.
- R4: Write ports that are enabled in the same cycle must use different addresses, and an assertion flags a clash. When the addresses differ, every one of those writes takes effect.
- R5: With `BYPASS`=1 (the default), a read of an address that a write port writes in the same cycle returns that port's write data in the next cycle.
- R6: A read of an address that is not being written returns the stored value, even while other ports write other addresses in the same cycle.
- R7: A write port whose `wr_en` bit is 0 changes no stored data, whatever its address and data inputs hold.
- R8: Each read port works independently. Read ports that present different addresses in the same cycle each return the value of their own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all banks and read registers |
| wr_en | input | NW | Write enable, one bit per write port |
| wr_addr | input | NW*AW | Write addresses; port k uses bits [k*AW +: AW] |
| wr_data | input | NW*WIDTH | Write data; port k uses bits [k*WIDTH +: WIDTH] |
| rd_addr | input | NR*AW | Read addresses; port r uses bits [r*AW +: AW] |
| rd_data | output | NR*WIDTH | Registered read data; port r uses bits [r*WIDTH +: WIDTH] |

## Verification
A read and a write can hit the same address in the same cycle. In that case the bypass path has to win over the encoded banks, which still hold the older contents. The bench provokes this with directed cycles in which every read port points at an address that one write port is writing. It also provokes it often during a long random run over a small address space. The behavioural model expects the write data in those cycles and the stored value in all others, and it compares every read port on every clock.

// File: rtl/xor_mpram.sv
module xor_mpram #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int NW     = 3,
  parameter int NR     = 2,
  parameter bit BYPASS = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NW-1:0]       wr_en,
  input  logic [NW*((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wr_addr,
  input  logic [NW*WIDTH-1:0] wr_data,
  input  logic [NR*((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_addr,
  output logic [NR*WIDTH-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] bank [NW][DEPTH];
  logic [WIDTH-1:0] enc  [NW];
  logic [WIDTH-1:0] rword [NR];
  logic [WIDTH-1:0] rq    [NR];

  // feedback: fold the other banks' words at this port's write address into the new data
  always_comb begin
    for (int k = 0; k < NW; k++) begin
      enc[k] = wr_data[k*WIDTH +: WIDTH];
      for (int j = 0; j < NW; j++)
        if (j != k) enc[k] = enc[k] ^ bank[j][wr_addr[k*AW +: AW]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NW; k++)
        for (int a = 0; a < DEPTH; a++)
          bank[k][a] <= '0;
    end else begin
      for (int k = 0; k < NW; k++)
        if (wr_en[k]) bank[k][wr_addr[k*AW +: AW]] <= enc[k];
    end
  end

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      rword[r] = '0;
      for (int j = 0; j < NW; j++)
        rword[r] = rword[r] ^ bank[j][rd_addr[r*AW +: AW]];
      if (BYPASS)
        for (int k = 0; k < NW; k++)
          if (wr_en[k] && wr_addr[k*AW +: AW] == rd_addr[r*AW +: AW])
            rword[r] = wr_data[k*WIDTH +: WIDTH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) rq[r] <= '0;
    end else begin
      for (int r = 0; r < NR; r++) rq[r] <= rword[r];
    end
  end

  genvar gr;
  generate
    for (gr = 0; gr < NR; gr++) begin : g_rd
      assign rd_data[gr*WIDTH +: WIDTH] = rq[gr];
    end
  endgenerate

  // R4: enabled write ports must not share an address
  genvar ga, gb;
  generate
    for (ga = 0; ga < NW; ga++) begin : g_clash_a
      for (gb = ga + 1; gb < NW; gb++) begin : g_clash_b
        a_r4_no_addr_clash: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en[ga] && wr_en[gb]) |-> (wr_addr[ga*AW +: AW] != wr_addr[gb*AW +: AW]));
      end
    end
  endgenerate

  // R1: read data is zero in the first cycle out of reset
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0));

  // R2: with no writes and a steady address, read data holds
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|wr_en) && !(|$past(wr_en)) && rd_addr == $past(rd_addr)) |=> $stable(rd_data));

  // R5: read during write to the same address returns the new data
  genvar gp, gq;
  generate
    if (BYPASS) begin : g_byp_chk
      for (gp = 0; gp < NR; gp++) begin : g_r
        for (gq = 0; gq < NW; gq++) begin : g_w
          a_r5_bypass_new: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[gq] && wr_addr[gq*AW +: AW] == rd_addr[gp*AW +: AW])
            |=> (rd_data[gp*WIDTH +: WIDTH] == $past(wr_data[gq*WIDTH +: WIDTH])));
        end
      end
    end
  endgenerate
endmodule

// File: tb/xor_mpram_tb_top.sv
module xor_mpram_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int NW = 3;
  localparam int NR = 2;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]       wr_en = '0;
  logic [NW*AW-1:0]    wr_addr = '0;
  logic [NW*WIDTH-1:0] wr_data = '0;
  logic [NR*AW-1:0]    rd_addr = '0;
  logic [NR*WIDTH-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic [WIDTH-1:0] model [DEPTH];
  logic [WIDTH-1:0] expv [NR];
  string etag [NR];
  bit pend = 1'b0;

  always #10 clk = ~clk;

  xor_mpram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NW(NW), .NR(NR), .BYPASS(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp, input int port);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s read port %0d: actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  task automatic step(input logic [NW-1:0] e, input logic [NW*AW-1:0] a,
                      input logic [NW*WIDTH-1:0] d, input logic [NR*AW-1:0] r, input string tag);
    @(negedge clk);
    if (pend)
      for (int p = 0; p < NR; p++) check(etag[p], rd_data[p*WIDTH +: WIDTH], expv[p], p);
    wr_en = e; wr_addr = a; wr_data = d; rd_addr = r;
    for (int p = 0; p < NR; p++) begin
      int ra = r[p*AW +: AW];
      expv[p] = model[ra];
      etag[p] = tag;
      for (int k = 0; k < NW; k++)
        if (e[k] && a[k*AW +: AW] == ra) begin
          expv[p] = d[k*WIDTH +: WIDTH];
          etag[p] = "R5";
        end
    end
    for (int k = 0; k < NW; k++)
      if (e[k]) model[a[k*AW +: AW]] = d[k*WIDTH +: WIDTH];
    pend = 1'b1;
  endtask

  function automatic logic [NW*AW-1:0] wa3(input int a0, input int a1, input int a2);
    return {a2[AW-1:0], a1[AW-1:0], a0[AW-1:0]};
  endfunction
  function automatic logic [NW*WIDTH-1:0] wd3(input int d0, input int d1, input int d2);
    return {d2[WIDTH-1:0], d1[WIDTH-1:0], d0[WIDTH-1:0]};
  endfunction
  function automatic logic [NR*AW-1:0] ra2(input int r0, input int r1);
    return {r1[AW-1:0], r0[AW-1:0]};
  endfunction

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NR; p++) check("R1", rd_data[p*WIDTH +: WIDTH], '0, p);
    rst_n = 1'b1;

    // R1: every address zero after reset
    for (int i = 0; i < DEPTH; i++) step('0, '0, '0, ra2(i, DEPTH-1-i), "R1");
    // R7: disabled ports with live address/data leave contents untouched
    step(3'b000, wa3(1, 2, 3), wd3(8'hAA, 8'hBB, 8'hCC), ra2(0, 0), "R7");
    step('0, '0, '0, ra2(1, 2), "R7");
    step('0, '0, '0, ra2(3, 3), "R7");
    // R4: three ports write distinct addresses each cycle
    for (int i = 0; i < DEPTH; i += 3)
      step(3'b111, wa3(i, (i+1) % DEPTH, (i+2) % DEPTH),
           wd3(8'h10 + i, 8'h40 + i, 8'h80 + i), ra2(0, 0), "R4");
    // R8/R2: read ports on distinct addresses changing each cycle
    for (int i = 0; i < DEPTH; i++) step('0, '0, '0, ra2(i, (i+5) % DEPTH), "R8");
    // R3: overwrite by a different port, then read
    step(3'b001, wa3(5, 0, 0), wd3(8'h11, 0, 0), ra2(0, 0), "R3");
    step(3'b100, wa3(0, 0, 5), wd3(0, 0, 8'h22), ra2(1, 1), "R3");
    step(3'b010, wa3(0, 5, 0), wd3(0, 8'h33, 0), ra2(5, 2), "R3");
    step('0, '0, '0, ra2(5, 5), "R3");
    // R2: steady address with no writes holds value
    step('0, '0, '0, ra2(5, 5), "R2");
    step('0, '0, '0, ra2(5, 5), "R2");
    // R5: read during write of the same address
    step(3'b011, wa3(7, 9, 0), wd3(8'h5A, 8'hA5, 0), ra2(7, 9), "R5");
    step(3'b100, wa3(0, 0, 7), wd3(0, 0, 8'hC3), ra2(7, 7), "R5");
    // R6: read untouched address while others write
    step(3'b111, wa3(1, 2, 3), wd3(8'h01, 8'h02, 8'h03), ra2(5, 9), "R6");
    step('0, '0, '0, ra2(1, 3), "R6");
    // random traffic, distinct write addresses per cycle
    for (int n = 0; n < 3000; n++) begin
      logic [NW-1:0] e;
      logic [NW*AW-1:0] a;
      logic [NW*WIDTH-1:0] d;
      logic [NR*AW-1:0] r;
      e = NW'($urandom);
      d = (NW*WIDTH)'({$urandom, $urandom});
      r = (NR*AW)'($urandom);
      for (int k = 0; k < NW; k++) a[k*AW +: AW] = AW'(($urandom % 5) * NW + k);
      step(e, a, d, r, "R3");
    end
    step('0, '0, '0, '0, "R3");
    @(negedge clk);
    for (int p = 0; p < NR; p++) check(etag[p], rd_data[p*WIDTH +: WIDTH], expv[p], p);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule